// File: doc/BRIEF.md
# Pixel Value Reconstructor for Multi-Checkpoint Exposure

This block turns one pixel's readout into a linear light value. A frame's exposure is checked at `NCHK` points; at each point the pixel may be reset, and a reset is only possible if the previous checkpoint also reset it. The stored per-checkpoint decisions therefore form a thermometer code. The block takes the digitized final sample (the mantissa) and that decision vector, counts the resets to get the exponent, and scales the mantissa by two to the power of that exponent with a left shift. The output is widened by `NCHK` bits so no scaled value is ever truncated.

A decision vector that breaks the thermometer rule (a reset recorded after a checkpoint with no reset) cannot arise from a correct capture. The block raises an error flag for it and uses only the unbroken run of resets from the first checkpoint as the exponent. One register stage separates input from output, and the valid qualifier travels with the data.

Top module: `pixel_value_recon`

## Requirements
- R1: While reset is asserted and after its release, until the first accepted sample, `out_valid`, `out_value`, `out_exp` and `out_err` are all zero.
- R2: `out_valid` equals `in_valid` delayed by exactly one clock; a sample presented with `in_valid` high appears on the outputs on the next clock edge.
- R3: `in_dec` bit 0 is the first checkpoint and bit k is checkpoint k+1. A legal vector has ones in bits 0..k-1 and zeros elsewhere (k from 0 to NCHK); for it `out_exp` is k and `out_err` is 0.
- R4: `out_value` equals `in_mant` shifted left by `out_exp`, zero-extended to MANT_W+NCHK bits, with no bit lost.
- R5: A vector with any 1 above its lowest 0 sets `out_err` to 1, and `out_exp` is then the count of consecutive ones starting at bit 0 (for example 4'b1101 gives 1, 4'b1110 gives 0).
- R6: For an illegal vector `out_value` is still the mantissa shifted by the exponent of R5.
- R7: While `in_valid` is low, `out_value`, `out_exp` and `out_err` keep the value of the last accepted sample, whatever `in_mant` and `in_dec` carry.
- R8: The all-ones vector gives `out_exp` = NCHK and the full-scale mantissa then fills the top MANT_W bits of `out_value`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample qualifier |
| in_mant | input | MANT_W | Digitized final pixel sample |
| in_dec | input | NCHK | Per-checkpoint reset decisions, bit 0 first |
| out_valid | output | 1 | Result qualifier, one cycle after `in_valid` |
| out_value | output | MANT_W+NCHK | Scaled linear value |
| out_exp | output | $clog2(NCHK+1) | Exponent (reset count) |
| out_err | output | 1 | Decision vector broke the thermometer rule |

## Verification
The assertions compare each output with the inputs of the previous cycle, so they assume inputs are driven well clear of the clock edge and that the values present just before reset release are defined. The bench drives every input on the falling edge, holds it through the next rising edge, and keeps all inputs at zero during reset. With a 6-bit mantissa and four checkpoints every mantissa is paired with every one of the sixteen decision vectors. Idle cycles with changing junk on the data inputs are mixed in so the hold behaviour is checked against a known previous result.

// File: rtl/recon_pkg.sv
package recon_pkg;

  localparam int unsigned MAX_CHK = 16;

  // count of consecutive ones starting at bit 0, limited to n bits
  function automatic int unsigned lead_ones(input logic [MAX_CHK-1:0] v,
                                            input int unsigned n);
    int unsigned cnt;
    logic        open;
    cnt  = 0;
    open = 1'b1;
    for (int unsigned i = 0; i < MAX_CHK; i++) begin
      if (i < n) begin
        if (open && v[i]) cnt = cnt + 1;
        else              open = 1'b0;
      end
    end
    return cnt;
  endfunction

  // true when some set bit lies above the leading run of ones
  function automatic logic broken_run(input logic [MAX_CHK-1:0] v,
                                      input int unsigned n);
    int unsigned run;
    logic        bad;
    run = lead_ones(v, n);
    bad = 1'b0;
    for (int unsigned i = 0; i < MAX_CHK; i++) begin
      if (i < n && i >= run && v[i]) bad = 1'b1;
    end
    return bad;
  endfunction

endpackage

// File: rtl/recon_decode.sv
module recon_decode
  import recon_pkg::*;
#(
  parameter int unsigned NCHK  = 4,
  parameter int unsigned EXP_W = $clog2(NCHK + 1)
) (
  input  logic [NCHK-1:0]  dec,
  output logic [EXP_W-1:0] run_len,
  output logic             bad_code
);
  logic [MAX_CHK-1:0] dec_ext;
  int unsigned        run_int;

  always_comb begin
    dec_ext = '0;
    dec_ext[NCHK-1:0] = dec;
    run_int  = lead_ones(dec_ext, NCHK);
    run_len  = EXP_W'(run_int);
    bad_code = broken_run(dec_ext, NCHK);
  end
endmodule

// File: rtl/recon_scale.sv
module recon_scale #(
  parameter int unsigned MANT_W = 10,
  parameter int unsigned NCHK   = 4,
  parameter int unsigned EXP_W  = $clog2(NCHK + 1),
  localparam int unsigned VAL_W = MANT_W + NCHK
) (
  input  logic [MANT_W-1:0] mant,
  input  logic [EXP_W-1:0]  shamt,
  output logic [VAL_W-1:0]  value
);
  // logarithmic shifter: stage s shifts by 2**s when shamt[s] is set
  logic [VAL_W-1:0] stage [EXP_W+1];

  assign stage[0] = {{NCHK{1'b0}}, mant};

  for (genvar s = 0; s < EXP_W; s++) begin : g_shift
    localparam int unsigned STEP = 1 << s;
    if (STEP < VAL_W) begin : g_live
      assign stage[s+1] = shamt[s] ? {stage[s][VAL_W-STEP-1:0], {STEP{1'b0}}}
                                   : stage[s];
    end else begin : g_flush
      assign stage[s+1] = shamt[s] ? '0 : stage[s];
    end
  end

  assign value = stage[EXP_W];
endmodule

// File: rtl/recon_stage.sv
module recon_stage #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              d_valid,
  input  logic [DATA_W-1:0] d_data,
  output logic              q_valid,
  output logic [DATA_W-1:0] q_data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
      q_data  <= '0;
    end else begin
      q_valid <= d_valid;
      if (d_valid) q_data <= d_data;
    end
  end
endmodule

// File: rtl/pixel_value_recon.sv
module pixel_value_recon #(
  parameter int unsigned MANT_W = 10,
  parameter int unsigned NCHK   = 4,
  localparam int unsigned EXP_W = $clog2(NCHK + 1),
  localparam int unsigned VAL_W = MANT_W + NCHK
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [MANT_W-1:0] in_mant,
  input  logic [NCHK-1:0]   in_dec,
  output logic              out_valid,
  output logic [VAL_W-1:0]  out_value,
  output logic [EXP_W-1:0]  out_exp,
  output logic              out_err
);
  localparam int unsigned PIPE_W = VAL_W + EXP_W + 1;

  // named internal events
  logic [EXP_W-1:0] exp_now;
  logic             err_now;
  logic [VAL_W-1:0] value_now;
  logic [PIPE_W-1:0] pipe_q;

  recon_decode #(.NCHK(NCHK), .EXP_W(EXP_W)) u_decode (
    .dec      (in_dec),
    .run_len  (exp_now),
    .bad_code (err_now)
  );

  recon_scale #(.MANT_W(MANT_W), .NCHK(NCHK), .EXP_W(EXP_W)) u_scale (
    .mant  (in_mant),
    .shamt (exp_now),
    .value (value_now)
  );

  recon_stage #(.DATA_W(PIPE_W)) u_stage (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_valid (in_valid),
    .d_data  ({err_now, exp_now, value_now}),
    .q_valid (out_valid),
    .q_data  (pipe_q)
  );

  assign {out_err, out_exp, out_value} = pipe_q;
endmodule

// File: rtl/pixel_value_recon_chk.sv
module pixel_value_recon_chk #(
  parameter int unsigned MANT_W = 10,
  parameter int unsigned NCHK   = 4,
  localparam int unsigned EXP_W = $clog2(NCHK + 1),
  localparam int unsigned VAL_W = MANT_W + NCHK
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [MANT_W-1:0] in_mant,
  input logic [NCHK-1:0]   in_dec,
  input logic              out_valid,
  input logic [VAL_W-1:0]  out_value,
  input logic [EXP_W-1:0]  out_exp,
  input logic              out_err
);
  p_valid_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_idle_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  p_exp_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_exp <= EXP_W'(NCHK));
  p_legal_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_err) |-> (int'(out_exp) == $countones($past(in_dec))));
  p_shift_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_value == (VAL_W'($past(in_mant)) << out_exp)));
  p_err_cover_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_err == (int'(out_exp) != $countones($past(in_dec)))));
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_value) && $stable(out_exp) && $stable(out_err)));
endmodule

bind pixel_value_recon pixel_value_recon_chk #(.MANT_W(MANT_W), .NCHK(NCHK)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_mant   (in_mant),
  .in_dec    (in_dec),
  .out_valid (out_valid),
  .out_value (out_value),
  .out_exp   (out_exp),
  .out_err   (out_err)
);

// File: tb/pixel_value_recon_bench.sv
module pixel_value_recon_bench;
  localparam int MW = 6;
  localparam int N  = 4;
  localparam int VW = MW + N;
  localparam int EW = $clog2(N + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [MW-1:0] in_mant = '0;
  logic [N-1:0]  in_dec = '0;
  logic          out_valid;
  logic [VW-1:0] out_value;
  logic [EW-1:0] out_exp;
  logic          out_err;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  logic [VW-1:0] last_val;
  logic [EW-1:0] last_exp;
  logic          last_err;

  always #2.5 clk = ~clk;

  pixel_value_recon #(.MANT_W(MW), .NCHK(N)) u_pixel_value_recon (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mant(in_mant),
    .in_dec(in_dec), .out_valid(out_valid), .out_value(out_value),
    .out_exp(out_exp), .out_err(out_err)
  );

  task automatic check(input string req, input string what,
                       input longint act, input longint exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // model: scan checkpoints from the first; stop at the first missing reset
  task automatic model(input int d, output int run, output int bad);
    bit gap;
    run = 0; bad = 0; gap = 0;
    for (int i = 0; i < N; i++) begin
      if (((d >> i) & 1) == 1) begin
        if (gap) bad = 1; else run++;
      end else gap = 1;
    end
  endtask

  task automatic apply(input int m, input int d);
    int run, bad;
    longint scaled;
    @(negedge clk);
    in_valid = 1'b1; in_mant = MW'(m); in_dec = N'(d);
    @(negedge clk);
    in_valid = 1'b0;
    model(d, run, bad);
    scaled = longint'(m) * (longint'(1) << run);
    check("R2", "out_valid", out_valid, 1);
    if (bad == 0) begin
      check("R3", "exp legal", out_exp, run);
      check("R3", "err legal", out_err, 0);
      check("R4", "value", out_value, scaled);
      if (run == N) check("R8", "full-scale value", out_value, scaled);
    end else begin
      check("R5", "exp illegal", out_exp, run);
      check("R5", "err illegal", out_err, 1);
      check("R6", "value illegal", out_value, scaled);
    end
    last_val = out_value; last_exp = out_exp; last_err = out_err;
  endtask

  task automatic idle_junk(input int m, input int d);
    in_valid = 1'b0; in_mant = MW'(m); in_dec = N'(d);
    @(negedge clk);
    check("R2", "idle out_valid", out_valid, 0);
    check("R7", "hold value", out_value, last_val);
    check("R7", "hold exp", out_exp, last_exp);
    check("R7", "hold err", out_err, last_err);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "valid in reset", out_valid, 0);
    check("R1", "value in reset", out_value, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "valid after reset", out_valid, 0);
    check("R1", "value after reset", out_value, 0);
    check("R1", "exp after reset", out_exp, 0);
    check("R1", "err after reset", out_err, 0);
    for (int d = 0; d < (1 << N); d++) begin
      for (int m = 0; m < (1 << MW); m++) begin
        apply(m, d);
        if (((m + d) % 7) == 0) idle_junk(~m, ~d);
      end
    end
    // R8: full-scale mantissa with every checkpoint reset
    apply((1 << MW) - 1, (1 << N) - 1);
    check("R8", "exp full", out_exp, N);
    idle_junk(0, 5);
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 150000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule